// File: doc/BRIEF.md
# Per-Bank Row Strobe Generator

This block turns one row strobe from a video memory controller into a set of active-low row strobes, one for each bank of a multi-bank video DRAM array. On an ordinary read, write or transfer cycle, only the bank named by the bank-select address bits gets a strobe. Every other bank stays idle in its low-power state. On a refresh cycle, which the block detects because the column strobe is already low when the row strobe falls, every bank is strobed together. This lets the whole array refresh in the fewest cycles.

The cycle type and the bank choice are captured on the falling edge of the row strobe. They are then held for as long as the row strobe stays low. When the row strobe rises, the held strobes are cleared at once, with no clock involved. An active-high reset forces every strobe inactive. The bank count is a parameter, and the select width follows from it. The default is four banks with a two-bit select.

Top module: `ras_bank_strobe_gen`

## Requirements
- R1: On a cycle where cas_n is high at the falling edge of ras_n, exactly one output goes low. The output is rasbk_n[k], where k is the unsigned value of bank_sel at that edge, so bank_sel=0 selects bit 0. All other outputs stay high.
- R2: If cas_n is low at the falling edge of ras_n, all bits of rasbk_n go low together.
- R3: A strobe pattern captured at the falling edge of ras_n holds unchanged for the whole time ras_n stays low.
- R4: Changes on bank_sel while ras_n is low have no effect on rasbk_n.
- R5: Changes on cas_n after ras_n has fallen do not change the cycle type already captured.
- R6: While ras_n is high, every bit of rasbk_n is high, whatever bank_sel and cas_n do.
- R7: The rising edge of ras_n returns all strobes high immediately and asynchronously, with no other clock.
- R8: While rst is high, all of rasbk_n is high. After rst is released, the strobes stay high until the next falling edge of ras_n.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst | input | 1 | Active-high reset, clears all strobes |
| ras_n | input | 1 | Controller row strobe, active low |
| cas_n | input | 1 | Controller column strobe, active low; low at row-strobe fall marks refresh |
| bank_sel | input | SEL_W (2) | Bank-select address bits, sampled at row-strobe fall |
| rasbk_n | output | NUM_BANKS (4) | Per-bank row strobes, active low |

## Verification
There is no clock inside the block. Every result is due in the same time step as the row-strobe or reset edge that causes it. The capture lands on the falling edge, and the clear lands on the rising edge or on reset. The bench changes its inputs just after a rising edge of its own pacing clock and reads rasbk_n at the next falling edge of that clock. Each result is therefore checked half a period after its cause, once it has settled. The hold checks are made after bank_sel and cas_n have been disturbed in a later pacing cycle. The idle checks are made after the inputs have changed with the row strobe high.

// File: rtl/ras_bank_pkg.sv
package ras_bank_pkg;

  typedef enum logic {
    CYC_ACCESS  = 1'b0,
    CYC_REFRESH = 1'b1
  } cyc_kind_e;

  function automatic cyc_kind_e kind_from_cas(input logic cas_n_at_fall);
    return cas_n_at_fall ? CYC_ACCESS : CYC_REFRESH;
  endfunction

endpackage

// File: rtl/ras_bank_decode.sv
module ras_bank_decode #(
  parameter int NUM_BANKS = 4,
  localparam int SEL_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic [SEL_W-1:0]     bank_sel,
  input  ras_bank_pkg::cyc_kind_e kind,
  output logic [NUM_BANKS-1:0] strobe_req
);

  // Active-high request per bank: refresh requests all, access requests one.
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_req
    assign strobe_req[b] = (kind == ras_bank_pkg::CYC_REFRESH) ||
                           (bank_sel == SEL_W'(b));
  end

endmodule

// File: rtl/ras_bank_hold.sv
module ras_bank_hold #(
  parameter int NUM_BANKS = 4
) (
  input  logic                 rst,
  input  logic                 ras_n,
  input  logic [NUM_BANKS-1:0] strobe_req,
  output logic [NUM_BANKS-1:0] held
);

  // One capture flop per bank: loads on ras_n fall, clears on ras_n rise or reset.
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    always_ff @(negedge ras_n or posedge ras_n or posedge rst) begin
      if (rst)
        held[b] <= 1'b0;
      else if (ras_n)
        held[b] <= 1'b0;
      else
        held[b] <= strobe_req[b];
    end
  end

endmodule

// File: rtl/ras_bank_strobe_gen.sv
module ras_bank_strobe_gen #(
  parameter int NUM_BANKS = 4,
  localparam int SEL_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                 rst,
  input  logic                 ras_n,
  input  logic                 cas_n,
  input  logic [SEL_W-1:0]     bank_sel,
  output logic [NUM_BANKS-1:0] rasbk_n
);
  import ras_bank_pkg::*;

  cyc_kind_e              kind_now;
  logic [NUM_BANKS-1:0]   strobe_req;
  logic [NUM_BANKS-1:0]   held;

  assign kind_now = kind_from_cas(cas_n);

  ras_bank_decode #(.NUM_BANKS(NUM_BANKS)) u_decode (
    .bank_sel   (bank_sel),
    .kind       (kind_now),
    .strobe_req (strobe_req)
  );

  ras_bank_hold #(.NUM_BANKS(NUM_BANKS)) u_hold (
    .rst        (rst),
    .ras_n      (ras_n),
    .strobe_req (strobe_req),
    .held       (held)
  );

  assign rasbk_n = ~held;

  // Cycle bookkeeping used only by the checks below.
  cyc_kind_e           kind_q;
  logic                live_q;
  logic [SEL_W-1:0]    sel_q;

  always_ff @(negedge ras_n or posedge ras_n or posedge rst) begin
    if (rst) begin
      kind_q <= CYC_ACCESS;
      live_q <= 1'b0;
      sel_q  <= '0;
    end else if (ras_n) begin
      live_q <= 1'b0;
    end else begin
      kind_q <= kind_now;
      live_q <= 1'b1;
      sel_q  <= bank_sel;
    end
  end

  AST_IDLE_HIGH: assert property (@(negedge ras_n) disable iff (rst)
    &rasbk_n);                                                    // R6
  AST_REFRESH_ALL: assert property (@(posedge ras_n) disable iff (rst)
    (live_q && kind_q == CYC_REFRESH) |-> (rasbk_n == '0));       // R2
  AST_ACCESS_ONEHOT: assert property (@(posedge ras_n) disable iff (rst)
    (live_q && kind_q == CYC_ACCESS) |-> ($countones(~rasbk_n) == 1)); // R1
  AST_SEL_HELD: assert property (@(posedge ras_n) disable iff (rst)
    (live_q && kind_q == CYC_ACCESS) |-> !rasbk_n[sel_q]);        // R3
  AST_DEAD_AFTER_RST: assert property (@(posedge ras_n) disable iff (rst)
    !live_q |-> (&rasbk_n));                                      // R8

endmodule

// File: tb/ras_bank_strobe_gen_test.sv
module ras_bank_strobe_gen_test;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 4;
  localparam int SW = 2;
  localparam int ITER = 150;

  logic clk = 1'b0;
  logic rst, ras_n, cas_n;
  logic [SW-1:0] bank_sel;
  logic [NB-1:0] rasbk_n;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ras_bank_strobe_gen #(.NUM_BANKS(NB)) uut (
    .rst(rst), .ras_n(ras_n), .cas_n(cas_n),
    .bank_sel(bank_sel), .rasbk_n(rasbk_n)
  );

  function automatic logic [NB-1:0] exp_strobes(input bit refresh, input int sel);
    logic [NB-1:0] v;
    v = '1;
    if (refresh) v = '0;
    else v[sel] = 1'b0;
    return v;
  endfunction

  task automatic chk(input string req, input logic [NB-1:0] exp);
    checks++;
    if (rasbk_n !== exp) begin
      fails++;
      $display("FAIL %s: rasbk_n=%b expected=%b", req, rasbk_n, exp);
    end
  endtask

  task automatic step(); @(posedge clk); endtask
  task automatic look(); @(negedge clk); endtask

  task automatic run_cycle(input bit refresh, input int sel);
    logic [NB-1:0] e;
    e = exp_strobes(refresh, sel);
    step(); bank_sel = SW'(sel); cas_n = refresh ? 1'b0 : 1'b1;
    look(); chk("R6 pre-fall idle", '1);
    step(); ras_n = 1'b0;
    look(); chk(refresh ? "R2 refresh all" : "R1 one bank", e);
    step(); bank_sel = SW'($urandom_range(NB-1)); cas_n = ~cas_n;
    look(); chk("R4 R5 hold after input change", e);
    step(); bank_sel = ~bank_sel;
    look(); chk("R3 held while low", e);
    step(); ras_n = 1'b1;
    look(); chk("R7 clear on rise", '1);
    step(); cas_n = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    fails++;
    $display("FAIL watchdog: expired, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h1bad5eed));
    rst = 1'b1; ras_n = 1'b1; cas_n = 1'b1; bank_sel = '0;
    look(); chk("R8 reset state", '1);
    step(); rst = 1'b0;
    look(); chk("R8 after release", '1);

    // R6: inputs wiggle with ras_n high
    for (int i = 0; i < 6; i++) begin
      step(); bank_sel = SW'(i); cas_n = i[0];
      look(); chk("R6 idle ignores inputs", '1);
    end

    // R1 each bank directed, R2 directed
    for (int b = 0; b < NB; b++) run_cycle(1'b0, b);
    run_cycle(1'b1, 0);
    run_cycle(1'b1, 3);

    // R8: reset during an active cycle, then release while ras_n low
    step(); bank_sel = 2'd2; cas_n = 1'b1;
    step(); ras_n = 1'b0;
    look(); chk("R1 before reset", exp_strobes(0, 2));
    step(); rst = 1'b1;
    look(); chk("R8 reset clears", '1);
    step(); rst = 1'b0;
    look(); chk("R8 stays high after release", '1);
    step(); bank_sel = 2'd1;
    look(); chk("R8 no recapture while low", '1);
    step(); ras_n = 1'b1;
    look(); chk("R7 idle after rise", '1);
    run_cycle(1'b0, 1);

    // random mix
    for (int i = 0; i < ITER; i++)
      run_cycle(($urandom_range(3) == 0), int'($urandom_range(NB-1)));

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule